// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sequences the power states of a small 8-bit microcontroller core. Software writes a power control register to request a light sleep (Idle) or a deep sleep (Stop). Idle halts only the CPU clock and leaves timers and serial ports clocked. Stop halts the peripheral clock as well. The request takes effect on the cycle the core marks the end of the current instruction. The block then chooses which wake-up events bring the core back to run. Any interrupt line ends Idle. Only an external interrupt ends Stop, or a power-fail event when the reference is configured to stay powered.

Two further registers sit beside the power control register. The clock-select register holds the two divider select bits. Writes to it are dropped while any serial port is still shifting, so a divider change cannot corrupt a transfer in flight. The reference control register holds one bit that keeps the power-fail reference powered through Stop. A read port returns any register one cycle after the address is presented. It includes a status word with the serial activity flags and the current mode.

Top module: `pwr_seq`

## Requirements
- R1: After a synchronous reset the mode is run, all register bits are 0, and cpu_clk_en, per_clk_en and ref_en are all 1.
- R2: A write of 1 to bit 0 of the power control register (address 0) requests Idle. In Idle, cpu_clk_en is 0 and per_clk_en stays 1.
- R3: A write of 1 to bit 1 of address 0 requests Stop, in which both clock enables are 0. When bits 0 and 1 are written 1 in the same write, only Stop is requested, and address 0 reads back 2.
- R4: A pending request changes the mode only at a clock edge where insn_done is 1. While insn_done stays 0, the core stays in run with both clock enables at 1.
- R5: In Idle, any bit of ext_irq or int_irq, or pf_event, returns the core to run at the next edge.
- R6: In Stop, the core returns to run only on a bit of ext_irq, or on pf_event when the reference-hold bit is 1. int_irq, and pf_event with the hold bit at 0, leave the core in Stop.
- R7: On the edge where a wake event is accepted, both power control bits clear to 0.
- R8: ref_en is 1 in every mode except Stop. In Stop it equals the reference-hold bit, which is bit 0 of address 2 and resets to 0.
- R9: A write to the clock-select register (address 1, bits 1:0) is ignored while any bit of ser_busy is 1.
- R10: rd_data shows, one cycle after rd_addr, the register at that address. Address 3 is status: bits 3:0 are ser_busy (rx0, tx0, rx1, tx1), bit 4 is Idle, bit 5 is Stop, and all other bits are 0.
- R11: Register writes are ignored while the core is in Idle or Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data |
| insn_done | input | 1 | End of the current instruction |
| ext_irq | input | 2 | Enabled external interrupt requests |
| int_irq | input | 4 | Enabled internal (timer, serial) interrupt requests |
| pf_event | input | 1 | Power-fail interrupt or reset request |
| ser_busy | input | 4 | Serial activity flags: rx0, tx0, rx1, tx1 |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| ref_en | output | 1 | Power-fail reference enable |

## Verification
Directed sequences enter Idle and Stop with insn_done held low, then raised. These show that entry waits for the instruction boundary and is not tied to the write itself. Each sleep mode is then offered internal interrupts, external interrupts and power-fail events, with the hold bit cleared and with it set. This separates the Idle wake set from the Stop wake set, and shows the effect of the hold bit. Writes are also made while a serial port is busy, while asleep, and with both power bits set at once, and a read-back shows that each was ignored or resolved as required. A long seeded random run then mixes writes, reads, instruction boundaries and sparse wake events, and compares every output on every cycle with a reference model in the bench.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    M_RUN  = 2'd0,
    M_IDLE = 2'd1,
    M_STOP = 2'd2
  } mode_t;

  // register addresses
  localparam logic [1:0] A_PCON  = 2'd0;
  localparam logic [1:0] A_CKSEL = 2'd1;
  localparam logic [1:0] A_RCON  = 2'd2;
  localparam logic [1:0] A_STAT  = 2'd3;

  // power control bit positions
  localparam int B_IDLE = 0;
  localparam int B_STOP = 1;
endpackage

// File: rtl/pwr_regs.sv
module pwr_regs
  import pwr_pkg::*;
#(
  parameter int AW     = 2,
  parameter int DW     = 8,
  parameter int BUSY_W = 4,
  parameter int CD_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              run_i,
  input  logic              is_idle_i,
  input  logic              is_stop_i,
  input  logic              wake_clr_i,
  input  logic [BUSY_W-1:0] busy_i,
  output logic              idl_nx,
  output logic              stp_nx,
  output logic              bgs_nx,
  output logic              bgs_q
);
  localparam int PAD_STAT = DW - BUSY_W - 2;

  logic            idl_q, stp_q;
  logic [CD_W-1:0] cd_q, cd_nx;
  logic            wr_ok, busy_any;

  assign wr_ok    = wr_en & run_i;
  assign busy_any = |busy_i;

  always_comb begin
    idl_nx = idl_q;
    stp_nx = stp_q;
    cd_nx  = cd_q;
    bgs_nx = bgs_q;
    if (wake_clr_i) begin
      idl_nx = 1'b0;
      stp_nx = 1'b0;
    end else if (wr_ok && wr_addr == A_PCON) begin
      stp_nx = wr_data[B_STOP];
      idl_nx = wr_data[B_IDLE] & ~wr_data[B_STOP];
    end
    if (wr_ok && wr_addr == A_CKSEL && !busy_any)
      cd_nx = wr_data[CD_W-1:0];
    if (wr_ok && wr_addr == A_RCON)
      bgs_nx = wr_data[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idl_q <= 1'b0;
      stp_q <= 1'b0;
      cd_q  <= '0;
      bgs_q <= 1'b0;
    end else begin
      idl_q <= idl_nx;
      stp_q <= stp_nx;
      cd_q  <= cd_nx;
      bgs_q <= bgs_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        A_PCON:  rd_data <= {{(DW-2){1'b0}}, stp_q, idl_q};
        A_CKSEL: rd_data <= {{(DW-CD_W){1'b0}}, cd_q};
        A_RCON:  rd_data <= {{(DW-1){1'b0}}, bgs_q};
        default: rd_data <= {{PAD_STAT{1'b0}}, is_stop_i, is_idle_i, busy_i};
      endcase
    end
  end

  // R9: divider select holds while a serial port is active
  a_r9_cd_locked: assert property (@(posedge clk) disable iff (rst)
    busy_any |=> $stable(cd_q));
  // R7: wake clears both power bits
  a_r7_wake_clears: assert property (@(posedge clk) disable iff (rst)
    wake_clr_i |=> (!idl_q && !stp_q));
  // R3: stop wins when both bits are written
  a_r3_stop_priority: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && wr_addr == A_PCON && wr_data[B_STOP]) |=> (stp_q && !idl_q));
  // R11: nothing changes through the bus while asleep
  a_r11_no_wr_asleep: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !wake_clr_i) |=> ($stable(cd_q) && $stable(bgs_q)));
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_pkg::*;
#(
  parameter int N_EXT = 2,
  parameter int N_INT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insn_done_i,
  input  logic             idl_nx_i,
  input  logic             stp_nx_i,
  input  logic             bgs_i,
  input  logic [N_EXT-1:0] ext_irq_i,
  input  logic [N_INT-1:0] int_irq_i,
  input  logic             pf_i,
  output mode_t            mode_q,
  output mode_t            mode_nx,
  output logic             wake_clr_o
);
  logic ext_any, int_any, wake_idle, wake_stop;

  assign ext_any   = |ext_irq_i;
  assign int_any   = |int_irq_i;
  assign wake_idle = ext_any | int_any | pf_i;
  assign wake_stop = ext_any | (bgs_i & pf_i);

  always_comb begin
    mode_nx    = mode_q;
    wake_clr_o = 1'b0;
    case (mode_q)
      M_RUN: begin
        if (insn_done_i && stp_nx_i)      mode_nx = M_STOP;
        else if (insn_done_i && idl_nx_i) mode_nx = M_IDLE;
      end
      M_IDLE: begin
        if (wake_idle) begin
          mode_nx    = M_RUN;
          wake_clr_o = 1'b1;
        end
      end
      M_STOP: begin
        if (wake_stop) begin
          mode_nx    = M_RUN;
          wake_clr_o = 1'b1;
        end
      end
      default: mode_nx = M_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= M_RUN;
    else     mode_q <= mode_nx;
  end

  // R4: no entry without an instruction boundary
  a_r4_entry_on_boundary: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_RUN && !insn_done_i) |=> (mode_q == M_RUN));
  // R6: stop ends only on external irq or held power-fail
  a_r6_stop_wake_src: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_STOP && !ext_any && !(bgs_i && pf_i)) |=> (mode_q == M_STOP));
  // R5: idle ends on any source
  a_r5_idle_wake: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_IDLE && wake_idle) |=> (mode_q == M_RUN));
endmodule

// File: rtl/pwr_clkgate.sv
module pwr_clkgate
  import pwr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t mode_nx_i,
  input  mode_t mode_q_i,
  input  logic  bgs_nx_i,
  input  logic  bgs_q_i,
  output logic  cpu_clk_en,
  output logic  per_clk_en,
  output logic  ref_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
      ref_en     <= 1'b1;
    end else begin
      cpu_clk_en <= (mode_nx_i == M_RUN);
      per_clk_en <= (mode_nx_i != M_STOP);
      ref_en     <= (mode_nx_i != M_STOP) | bgs_nx_i;
    end
  end

  // R8: reference enable tracks mode and hold bit
  a_r8_ref_outside_stop: assert property (@(posedge clk) disable iff (rst)
    (mode_q_i != M_STOP) |-> ref_en);
  a_r8_ref_off_in_stop: assert property (@(posedge clk) disable iff (rst)
    (mode_q_i == M_STOP && !bgs_q_i) |-> !ref_en);
  // R2: peripheral clock only stops in Stop
  a_r2_per_clk_idle: assert property (@(posedge clk) disable iff (rst)
    (mode_q_i == M_IDLE) |-> (per_clk_en && !cpu_clk_en));
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_pkg::*;
#(
  parameter int AW     = 2,
  parameter int DW     = 8,
  parameter int N_EXT  = 2,
  parameter int N_INT  = 4,
  parameter int BUSY_W = 4,
  parameter int CD_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              insn_done,
  input  logic [N_EXT-1:0]  ext_irq,
  input  logic [N_INT-1:0]  int_irq,
  input  logic              pf_event,
  input  logic [BUSY_W-1:0] ser_busy,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              ref_en
);
  mode_t mode_q, mode_nx;
  logic  idl_nx, stp_nx, bgs_nx, bgs_q, wake_clr;

  pwr_regs #(.AW(AW), .DW(DW), .BUSY_W(BUSY_W), .CD_W(CD_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .run_i(mode_q == M_RUN),
    .is_idle_i(mode_q == M_IDLE),
    .is_stop_i(mode_q == M_STOP),
    .wake_clr_i(wake_clr), .busy_i(ser_busy),
    .idl_nx(idl_nx), .stp_nx(stp_nx), .bgs_nx(bgs_nx), .bgs_q(bgs_q)
  );

  pwr_fsm #(.N_EXT(N_EXT), .N_INT(N_INT)) u_fsm (
    .clk(clk), .rst(rst), .insn_done_i(insn_done),
    .idl_nx_i(idl_nx), .stp_nx_i(stp_nx), .bgs_i(bgs_q),
    .ext_irq_i(ext_irq), .int_irq_i(int_irq), .pf_i(pf_event),
    .mode_q(mode_q), .mode_nx(mode_nx), .wake_clr_o(wake_clr)
  );

  pwr_clkgate u_gate (
    .clk(clk), .rst(rst),
    .mode_nx_i(mode_nx), .mode_q_i(mode_q),
    .bgs_nx_i(bgs_nx), .bgs_q_i(bgs_q),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .ref_en(ref_en)
  );
endmodule

// File: tb/pwr_seq_bench.sv
`timescale 1ns/1ps
module pwr_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       insn_done = 1'b0;
  logic [1:0] ext_irq = '0;
  logic [3:0] int_irq = '0;
  logic       pf_event = 1'b0;
  logic [3:0] ser_busy = '0;
  logic       cpu_clk_en, per_clk_en, ref_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state: mode 0 run, 1 idle, 2 stop
  int       m_mode;
  logic     m_idl, m_stp, m_bgs;
  logic [1:0] m_cd;

  always #2 clk = ~clk;

  pwr_seq u_pwr_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .insn_done(insn_done),
    .ext_irq(ext_irq), .int_irq(int_irq), .pf_event(pf_event),
    .ser_busy(ser_busy), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .ref_en(ref_en)
  );

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_model(input logic [1:0] a);
    case (a)
      2'd0:    return {6'b0, m_stp, m_idl};
      2'd1:    return {6'b0, m_cd};
      2'd2:    return {7'b0, m_bgs};
      default: return {2'b0, m_mode == 2, m_mode == 1, ser_busy};
    endcase
  endfunction

  // one cycle: drive at negedge, model the edge, check after it
  task automatic step(input string tag, input logic w, input logic [1:0] wa,
                      input logic [7:0] wd, input logic [1:0] ra, input logic id,
                      input logic [1:0] ex, input logic [3:0] it, input logic pf,
                      input logic [3:0] bz);
    logic wr_ok, wake, n_idl, n_stp, n_bgs;
    logic [1:0] n_cd;
    logic [7:0] exp_rd;
    int n_mode;
    @(negedge clk);
    wr_en = w; wr_addr = wa; wr_data = wd; rd_addr = ra; insn_done = id;
    ext_irq = ex; int_irq = it; pf_event = pf; ser_busy = bz;
    exp_rd = rd_model(ra);
    wr_ok = w && m_mode == 0;
    wake = (m_mode == 1) ? ((|ex) || (|it) || pf)
         : (m_mode == 2) ? ((|ex) || (m_bgs && pf)) : 1'b0;
    n_idl = m_idl; n_stp = m_stp; n_cd = m_cd; n_bgs = m_bgs;
    if (wake) begin n_idl = 0; n_stp = 0; end
    else if (wr_ok && wa == 2'd0) begin n_stp = wd[1]; n_idl = wd[0] & ~wd[1]; end
    if (wr_ok && wa == 2'd1 && bz == 4'd0) n_cd = wd[1:0];
    if (wr_ok && wa == 2'd2) n_bgs = wd[0];
    n_mode = m_mode;
    if (wake) n_mode = 0;
    else if (m_mode == 0 && id && n_stp) n_mode = 2;
    else if (m_mode == 0 && id && n_idl) n_mode = 1;
    m_mode = n_mode; m_idl = n_idl; m_stp = n_stp; m_cd = n_cd; m_bgs = n_bgs;
    @(posedge clk); #1;
    chk(tag, "cpu_clk_en", {7'b0, cpu_clk_en}, {7'b0, m_mode == 0});
    chk(tag, "per_clk_en", {7'b0, per_clk_en}, {7'b0, m_mode != 2});
    chk(tag, "ref_en", {7'b0, ref_en}, {7'b0, (m_mode != 2) || m_bgs});
    chk(tag, "rd_data", rd_data, exp_rd);
  endtask

  task automatic idle_step(input string tag, input logic [1:0] ra);
    step(tag, 0, 0, 0, ra, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0011;
    void'($urandom(seed));
    m_mode = 0; m_idl = 0; m_stp = 0; m_bgs = 0; m_cd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state of every register and output
    for (int a = 0; a < 4; a++) idle_step("R1", a[1:0]);
    // R10 status layout with busy flags
    step("R10", 0, 0, 0, 2'd3, 0, 0, 0, 0, 4'b1010);
    idle_step("R10", 2'd3);
    // R2 idle entry, R5 wake by internal irq, R7 bits cleared
    step("R2", 1, 2'd0, 8'h01, 2'd0, 1, 0, 0, 0, 0);
    idle_step("R2", 2'd3);
    step("R11", 1, 2'd2, 8'h01, 2'd2, 0, 0, 0, 0, 0); // R11 write while idle
    idle_step("R11", 2'd2);
    step("R5", 0, 0, 0, 2'd0, 0, 0, 4'b0100, 0, 0);
    idle_step("R7", 2'd0);
    // R4 stop requested without boundary, then boundary
    step("R4", 1, 2'd0, 8'h02, 2'd0, 0, 0, 0, 0, 0);
    idle_step("R4", 2'd0);
    step("R4", 0, 0, 0, 2'd0, 1, 0, 0, 0, 0);
    // R6 stop ignores internal irq and power-fail with hold bit 0
    step("R6", 0, 0, 0, 2'd3, 0, 0, 4'b1111, 0, 0);
    step("R8", 0, 0, 0, 2'd2, 0, 0, 0, 1, 0);
    step("R6", 0, 0, 0, 2'd0, 0, 2'b10, 0, 0, 0);
    idle_step("R7", 2'd0);
    // R3 both bits written: stop only
    step("R3", 1, 2'd0, 8'h03, 2'd0, 1, 0, 0, 0, 0);
    idle_step("R3", 2'd0);
    step("R6", 0, 0, 0, 2'd0, 0, 2'b01, 0, 0, 0);
    // R8 hold bit keeps reference, power-fail then wakes stop
    step("R8", 1, 2'd2, 8'h01, 2'd2, 0, 0, 0, 0, 0);
    step("R8", 1, 2'd0, 8'h02, 2'd2, 1, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 2'd0, 0, 0, 0, 1, 0);
    idle_step("R7", 2'd0);
    // R9 divider write while busy is dropped, accepted when quiet
    step("R9", 1, 2'd1, 8'h03, 2'd1, 0, 0, 0, 0, 4'b0001);
    idle_step("R9", 2'd1);
    step("R9", 1, 2'd1, 8'h02, 2'd1, 0, 0, 0, 0, 4'b0000);
    idle_step("R9", 2'd1);
    // seeded random traffic
    for (int i = 0; i < 4000; i++) begin
      logic w, id, pf;
      logic [1:0] wa, ra, ex;
      logic [7:0] wd;
      logic [3:0] it, bz;
      w  = ($urandom % 10) < 3;
      wa = 2'($urandom);
      wd = 8'($urandom);
      ra = 2'($urandom);
      id = ($urandom % 2) == 0;
      ex = (($urandom % 20) == 0) ? 2'($urandom) : 2'b00;
      it = (($urandom % 10) == 0) ? 4'($urandom) : 4'b0000;
      pf = ($urandom % 16) == 0;
      bz = (($urandom % 2) == 0) ? 4'($urandom) : 4'b0000;
      step("R2/R3/R5/R6/R8/R9/R10", w, wa, wd, ra, id, ex, it, pf, bz);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule